// File: doc/BRIEF.md
# Loss-of-Frame Integration Monitor

This block sits behind a frame aligner and turns its raw out-of-frame indication into a steady loss-of-frame flag. The aligner gives two inputs. One is a strobe that lasts one cycle at each frame boundary. The other is the out-of-frame level. The monitor samples that level only on a strobe. It keeps two run counters. One counts boundaries seen in the out-of-frame state and the other counts boundaries seen in frame. Any boundary in the opposite state sends a counter back to zero.

The flag rises after a long unbroken run of out-of-frame boundaries, 24 by default, which is about 3 ms at 8 kHz frames. Once raised, the flag falls only after an unbroken run of in-frame boundaries. A one-bit select input sets the length of that run: 24 boundaries when the select is 0 and 8 when it is 1. Because the two thresholds differ and each run restarts on any break, the flag has hysteresis. Each time the flag changes, in either direction, a pulse one cycle long appears beside it. That pulse can feed an interrupt collector outside this block.

Top module: `lof_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `lof` is 0 and `lof_delta` is 0.
- R2: With `lof` at 0, `lof` goes to 1 on the 24th consecutive boundary strobe sampled with `oof`=1. It stays 0 through the 23rd.
- R3: A boundary sampled with `oof`=0 while `lof` is 0 restarts the declare run. After 23 out-of-frame boundaries, one in-frame boundary, then 23 more out-of-frame boundaries, `lof` is still 0. One further out-of-frame boundary sets it.
- R4: With `lof` at 1 and `clr_sel`=0, `lof` goes to 0 on the 24th consecutive boundary sampled with `oof`=0. It stays 1 through the 23rd.
- R5: With `lof` at 1 and `clr_sel`=1, `lof` goes to 0 on the 8th consecutive in-frame boundary. It stays 1 through the 7th.
- R6: A boundary sampled with `oof`=1 while `lof` is 1 restarts the clear run.
- R7: `oof` has no effect in cycles without a boundary strobe. Holding `oof`=1 for many strobe-free cycles neither sets `lof` nor advances the declare run.
- R8: `lof_delta` is 1 for exactly the one cycle after each edge on which `lof` changes, for both rise and fall, and is 0 at all other times.
- R9: `lof` changes only on the clock edge that samples a boundary strobe. The new value is visible in the cycle after that strobe.
- R10: `clr_sel` is evaluated at each in-frame boundary against the run so far, counting that boundary. If `clr_sel` changes from 0 to 1 after 10 in-frame boundaries, the next in-frame boundary clears `lof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe at each frame boundary |
| oof | input | 1 | Out-of-frame level from the aligner |
| clr_sel | input | 1 | Clear-run select: 0 means 24 boundaries, 1 means 8 |
| lof | output | 1 | Loss-of-frame flag |
| lof_delta | output | 1 | One-cycle pulse on every change of `lof` |

## Verification
Both outputs are registered on the same edge that samples a strobe, so a change in `lof` and its `lof_delta` pulse show up together one cycle after the strobe. The bench raises each strobe at a falling edge and lowers it at the next falling edge. It samples both outputs at that second falling edge, which is half a cycle after the deciding rising edge. Between strobes it leaves idle cycles and samples `lof_delta` again to confirm that the pulse lasted one cycle. In every run the bench counts the boundaries one by one, so it checks the count just below each threshold and the count exactly at it.

// File: rtl/lof_pkg.sv
package lof_pkg;

  // Outcome of one boundary as seen by the flag register
  typedef enum logic [1:0] {
    EV_HOLD  = 2'd0,
    EV_SET   = 2'd1,
    EV_CLEAR = 2'd2
  } lof_ev_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lof_run_counter.sv
// Saturating run counter: on a boundary it increments when hit=1 and
// returns to zero otherwise.
module lof_run_counter #(
  parameter int SAT_VAL = 24,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hit,
  output logic [CNT_W-1:0] run
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

  logic [CNT_W-1:0] run_d;
  logic             run_en;

  assign run_en = tick;

  always_comb begin
    if (!hit)            run_d = '0;
    else if (run == SAT) run_d = SAT;
    else                 run_d = run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (run_en) run <= run_d;
  end
endmodule

// File: rtl/lof_clear_limit.sv
// Chooses the clear-run limit (last count before clearing) from the select.
module lof_clear_limit #(
  parameter int SLOW_FRAMES = 24,
  parameter int FAST_FRAMES = 8,
  parameter int CNT_W       = 5
) (
  input  logic             sel_fast,
  output logic [CNT_W-1:0] last_cnt
);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_FRAMES - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_FRAMES - 1);

  generate
    if (SLOW_FRAMES == FAST_FRAMES) begin : g_same
      logic unused_sel;
      assign unused_sel = sel_fast;
      assign last_cnt   = SLOW_LAST;
    end else begin : g_mux
      assign last_cnt = sel_fast ? FAST_LAST : SLOW_LAST;
    end
  endgenerate
endmodule

// File: rtl/lof_flag.sv
// Hysteretic flag register with change pulse.
module lof_flag #(
  parameter int DECLARE_FRAMES = 24,
  parameter int CNT_W          = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             oof,
  input  logic [CNT_W-1:0] oof_run,
  input  logic [CNT_W-1:0] inf_run,
  input  logic [CNT_W-1:0] clr_last,
  output logic             flag,
  output logic             delta
);
  import lof_pkg::*;

  localparam logic [CNT_W-1:0] DECL_LAST = CNT_W'(DECLARE_FRAMES - 1);

  lof_ev_t ev;
  logic    flag_d;

  always_comb begin
    ev = EV_HOLD;
    if (tick) begin
      if (!flag && oof && (oof_run >= DECL_LAST))
        ev = EV_SET;
      else if (flag && !oof && (inf_run >= clr_last))
        ev = EV_CLEAR;
    end
  end

  always_comb begin
    case (ev)
      EV_SET:   flag_d = 1'b1;
      EV_CLEAR: flag_d = 1'b0;
      default:  flag_d = flag;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      delta <= 1'b0;
    end else begin
      flag  <= flag_d;
      delta <= (ev != EV_HOLD);
    end
  end
endmodule

// File: rtl/lof_monitor.sv
module lof_monitor #(
  parameter int DECLARE_FRAMES    = 24,
  parameter int CLEAR_SLOW_FRAMES = 24,
  parameter int CLEAR_FAST_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic oof,
  input  logic clr_sel,
  output logic lof,
  output logic lof_delta
);
  localparam int MAX_RUN = lof_pkg::max3(DECLARE_FRAMES, CLEAR_SLOW_FRAMES,
                                         CLEAR_FAST_FRAMES);
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] oof_run;
  logic [CNT_W-1:0] inf_run;
  logic [CNT_W-1:0] clr_last;
  logic             inframe;

  assign inframe = ~oof;

  lof_run_counter #(.SAT_VAL(MAX_RUN), .CNT_W(CNT_W)) u_oof_run (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .hit(oof), .run(oof_run)
  );

  lof_run_counter #(.SAT_VAL(MAX_RUN), .CNT_W(CNT_W)) u_inf_run (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .hit(inframe), .run(inf_run)
  );

  lof_clear_limit #(
    .SLOW_FRAMES(CLEAR_SLOW_FRAMES),
    .FAST_FRAMES(CLEAR_FAST_FRAMES),
    .CNT_W(CNT_W)
  ) u_limit (
    .sel_fast(clr_sel), .last_cnt(clr_last)
  );

  lof_flag #(.DECLARE_FRAMES(DECLARE_FRAMES), .CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .oof(oof),
    .oof_run(oof_run), .inf_run(inf_run), .clr_last(clr_last),
    .flag(lof), .delta(lof_delta)
  );
endmodule

// File: rtl/lof_monitor_chk.sv
module lof_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic oof,
  input logic lof,
  input logic lof_delta
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!lof && !lof_delta);
    end
  end

  // R8
  delta_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lof != $past(lof)) == lof_delta);

  // R8
  delta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lof_delta |=> !lof_delta);

  // R9
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(lof));

  // R2
  rise_needs_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(oof));

  // R4
  fall_needs_inframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> !$past(oof));
endmodule

bind lof_monitor lof_monitor_chk u_lof_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .oof(oof),
  .lof(lof), .lof_delta(lof_delta)
);

// File: tb/tb_lof_monitor.sv
module tb_lof_monitor;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_tick;
  logic oof;
  logic clr_sel;
  logic lof;
  logic lof_delta;

  int total = 0;
  int bad   = 0;
  logic got_lof;
  logic got_delta;

  always #2 clk = ~clk;

  lof_monitor dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .oof(oof),
    .clr_sel(clr_sel), .lof(lof), .lof_delta(lof_delta)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frame_tick = 1'b0; oof = 1'b0; clr_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One boundary; outputs sampled half a cycle after the deciding edge
  task automatic frame(input logic v);
    @(negedge clk);
    frame_tick = 1'b1; oof = v;
    @(negedge clk);
    frame_tick = 1'b0;
    got_lof = lof; got_delta = lof_delta;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(input int n, input logic v);
    for (int i = 0; i < n; i++) frame(v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_tick = 1'b0; oof = 1'b1; clr_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 lof in reset", lof, 1'b0);
    check("R1 delta in reset", lof_delta, 1'b0);
    rst_n = 1'b1; oof = 1'b0;
    @(negedge clk);
    check("R1 lof after release", lof, 1'b0);
    check("R1 delta after release", lof_delta, 1'b0);
  endtask

  task automatic t_declare();
    do_reset();
    frames(23, 1'b1);
    check("R2 lof after 23", got_lof, 1'b0);
    frame(1'b1);
    check("R2 lof after 24", got_lof, 1'b1);
    check("R8 delta on rise", got_delta, 1'b1);
    check("R8 delta one cycle", lof_delta, 1'b0);
  endtask

  task automatic t_clear_slow();
    clr_sel = 1'b0;
    frames(23, 1'b0);
    check("R4 lof after 23 in-frame", got_lof, 1'b1);
    check("R8 no delta while held", got_delta, 1'b0);
    frame(1'b0);
    check("R4 lof after 24 in-frame", got_lof, 1'b0);
    check("R8 delta on fall", got_delta, 1'b1);
    check("R8 fall delta one cycle", lof_delta, 1'b0);
  endtask

  task automatic t_restart_declare();
    do_reset();
    frames(23, 1'b1);
    frame(1'b0);
    frames(23, 1'b1);
    check("R3 lof after broken run", got_lof, 1'b0);
    frame(1'b1);
    check("R3 lof after full run", got_lof, 1'b1);
  endtask

  task automatic t_clear_fast();
    clr_sel = 1'b1;
    frames(7, 1'b0);
    check("R5 lof after 7 in-frame", got_lof, 1'b1);
    frame(1'b1);
    frames(7, 1'b0);
    check("R6 lof after restart 7", got_lof, 1'b1);
    frame(1'b0);
    check("R5 lof after 8 in-frame", got_lof, 1'b0);
    check("R8 delta on fast fall", got_delta, 1'b1);
  endtask

  task automatic t_no_tick();
    do_reset();
    frame(1'b0);
    oof = 1'b1;
    repeat (100) @(negedge clk);
    check("R7 lof with no strobe", lof, 1'b0);
    check("R7 delta with no strobe", lof_delta, 1'b0);
    frames(23, 1'b1);
    check("R7 run not advanced", got_lof, 1'b0);
    frame(1'b1);
    check("R7 set after 24", got_lof, 1'b1);
  endtask

  task automatic t_sel_change();
    clr_sel = 1'b0;
    frames(10, 1'b0);
    check("R10 lof held after 10", got_lof, 1'b1);
    clr_sel = 1'b1;
    frame(1'b0);
    check("R10 clear on sel change", got_lof, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_declare();
    t_clear_slow();
    t_restart_declare();
    t_clear_fast();
    t_no_tick();
    t_sel_change();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule